// File: doc/BRIEF.md
# Modem Status Change Tracker

This block keeps the four modem input levels of a 16550-style serial port (clear-to-send, data-set-ready, ring indicator, carrier detect) and a change flag for each. It presents them as the modem status byte. It also holds the modem control byte and drives it out. When the control byte selects loopback, the block ignores the external lines. Each effective input level is then taken from one of the modem control outputs.

Change flags are found by comparing the effective levels from one cycle to the next. Any event that moves an effective level therefore raises a flag. This covers a real line transition, a control write while in loopback, and entering or leaving loopback. A read strobe on the status byte clears the flags. The read returns the flags as they stood before the clear. A change detected in the same cycle as the read is kept.

Top module: `modem_status_tracker`

## Requirements
- R1: After reset, with all external lines low, `mcr_q` is 0x00, `msr_o` is 0x00 and `delta_any` is 0.
- R2: A cycle with `mcr_wr` high stores `mcr_wdata` into `mcr_q` at that edge, with bits 7:5 forced to zero. Control bit 0 is DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2 and bit 4 the loopback enable.
- R3: While loopback is enabled, the effective levels follow the control outputs: CTS follows DTR, DSR follows RTS, RI follows OUT1 and DCD follows OUT2.
- R4: When the effective CTS, DSR or DCD level differs from its value in the previous cycle, the matching flag is set at the next clock edge. This includes changes caused by entering or leaving loopback.
- R5: The RI flag is set only when effective RI goes from high to low. A rising RI sets no flag.
- R6: The status byte gives the flags in bits 3:0 (CTS change, DSR change, RI trailing edge, DCD change) and the levels in bits 7:4 (CTS, DSR, RI, DCD). A cycle with `msr_rd` high presents the flags, and they are cleared at the end of that cycle.
- R7: A flag raised at the same edge as a read clear stays set after the read.
- R8: A level change on an external line appears in the status byte two clock edges later. Its flag appears one edge after that.
- R9: While loopback is enabled, activity on the external lines changes neither the status byte nor `delta_any`.
- R10: `delta_any` is high exactly when at least one of the four flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_cts | input | 1 | External clear-to-send level, asynchronous |
| line_dsr | input | 1 | External data-set-ready level, asynchronous |
| line_ri | input | 1 | External ring indicator level, asynchronous |
| line_dcd | input | 1 | External carrier detect level, asynchronous |
| mcr_wr | input | 1 | Write strobe for the modem control byte |
| mcr_wdata | input | 8 | Modem control byte to store |
| msr_rd | input | 1 | Read strobe for the status byte; clears the flags |
| mcr_q | output | 8 | Stored modem control byte |
| msr_o | output | 8 | Modem status byte |
| delta_any | output | 1 | At least one change flag is set |

## Verification
The hardest case to reach is a line change whose flag is raised at the same edge as a read clear. The bench counts the synchronizer stages so that the read strobe lands exactly on the third edge after an external line moves. It then checks both the byte returned during the read and the flag left afterwards. Mode-switch flags are hard to reach as well. They are reached by leaving external levels that differ from the control outputs and then toggling loopback, so the switch alone moves the effective levels.

// File: rtl/mst_pkg.sv
// Shared types and bit positions for the modem status tracker.
package mst_pkg;
    // Effective modem levels packed so that the layout matches status bits 7:4.
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } modem_lv_t;

    localparam int MCR_W        = 8;
    localparam int MCR_DTR      = 0;
    localparam int MCR_RTS      = 1;
    localparam int MCR_OUT1     = 2;
    localparam int MCR_OUT2     = 3;
    localparam int MCR_LOOP     = 4;
    localparam int MCR_USED     = 5;
    localparam int FLAG_CTS     = 0;
    localparam int FLAG_DSR     = 1;
    localparam int FLAG_RI_FALL = 2;
    localparam int FLAG_DCD     = 3;
endpackage

// File: rtl/mst_sync.sv
// Multi-stage synchronizer for asynchronous modem inputs.
// Assumes: STAGES >= 2; each bit is synchronized on its own (levels, not buses).
module mst_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage captures the raw line levels.
            always_ff @(posedge clk) begin
                if (!rst_n) st[i] <= '0;
                else        st[i] <= d;
            end
        end else begin : g_rest
            // Later stages shift the previous stage forward.
            always_ff @(posedge clk) begin
                if (!rst_n) st[i] <= '0;
                else        st[i] <= st[i-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/mst_effective.sv
// Selects the effective modem levels: the synchronized lines in normal
// operation, or the modem control outputs in loopback.
// Assumes: mcr uses the bit positions listed in mst_pkg.
module mst_effective
    import mst_pkg::*;
(
    input  modem_lv_t              line_lv,
    input  logic [MCR_W-1:0]       mcr,
    output modem_lv_t              eff_lv
);
    // Loopback mux, purely combinational.
    always_comb begin
        if (mcr[MCR_LOOP]) begin
            eff_lv.cts = mcr[MCR_DTR];
            eff_lv.dsr = mcr[MCR_RTS];
            eff_lv.ri  = mcr[MCR_OUT1];
            eff_lv.dcd = mcr[MCR_OUT2];
        end else begin
            eff_lv = line_lv;
        end
    end
endmodule

// File: rtl/mst_delta.sv
// Change-flag register: compares the effective levels with last cycle's copy,
// sets CTS/DSR/DCD flags on any change and the RI flag on a falling edge,
// and clears all flags on a read unless a new change arrives at the same edge.
// Assumes: the previous-level copy resets to all zero, matching reset lines.
module mst_delta
    import mst_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  modem_lv_t eff_lv,
    input  logic      rd,
    output logic [3:0] flags
);
    modem_lv_t  prev_lv;
    logic [3:0] hit;

    // Detect per-bit events between last cycle's and this cycle's levels.
    always_comb begin
        hit               = '0;
        hit[FLAG_CTS]     = eff_lv.cts ^ prev_lv.cts;
        hit[FLAG_DSR]     = eff_lv.dsr ^ prev_lv.dsr;
        hit[FLAG_RI_FALL] = prev_lv.ri & ~eff_lv.ri;
        hit[FLAG_DCD]     = eff_lv.dcd ^ prev_lv.dcd;
    end

    // Track the previous effective levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lv <= '0;
        else        prev_lv <= eff_lv;
    end

    // Sticky flags; a read clears them but a fresh event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (rd ? 4'b0000 : flags) | hit;
    end

    // R4
    cts_change_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_lv.cts != prev_lv.cts) |=> flags[FLAG_CTS]);
    // R4
    dcd_change_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_lv.dcd != prev_lv.dcd) |=> flags[FLAG_DCD]);
    // R5
    ri_rise_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[FLAG_RI_FALL] && !(prev_lv.ri && !eff_lv.ri)) |=> !flags[FLAG_RI_FALL]);
    // R6
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (($past(flags) & ~flags) == 4'b0000));
endmodule

// File: rtl/modem_status_tracker.sv
// Modem status tracker: stores the modem control byte, synchronizes the four
// modem lines, applies loopback and keeps sticky change flags.
// Assumes: a status read is a single-cycle msr_rd pulse; msr_o is valid in it.
module modem_status_tracker
    import mst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_cts,
    input  logic             line_dsr,
    input  logic             line_ri,
    input  logic             line_dcd,
    input  logic             mcr_wr,
    input  logic [MCR_W-1:0] mcr_wdata,
    input  logic             msr_rd,
    output logic [MCR_W-1:0] mcr_q,
    output logic [7:0]       msr_o,
    output logic             delta_any
);
    localparam logic [MCR_W-1:0] MCR_KEEP = MCR_W'((1 << MCR_USED) - 1);

    modem_lv_t  raw_lv;
    modem_lv_t  sync_lv;
    modem_lv_t  eff_lv;
    logic [3:0] flags;

    assign raw_lv = '{dcd: line_dcd, ri: line_ri, dsr: line_dsr, cts: line_cts};

    // Modem control byte with reserved bits dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)      mcr_q <= '0;
        else if (mcr_wr) mcr_q <= mcr_wdata & MCR_KEEP;
    end

    mst_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lv),
        .q     (sync_lv)
    );

    mst_effective u_eff (
        .line_lv (sync_lv),
        .mcr     (mcr_q),
        .eff_lv  (eff_lv)
    );

    mst_delta u_delta (
        .clk    (clk),
        .rst_n  (rst_n),
        .eff_lv (eff_lv),
        .rd     (msr_rd),
        .flags  (flags)
    );

    assign msr_o     = {eff_lv, flags};
    assign delta_any = |flags;

    // R2
    mcr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_wr |=> (mcr_q[MCR_USED-1:0] == $past(mcr_wdata[MCR_USED-1:0])) &&
                   (mcr_q[MCR_W-1:MCR_USED] == '0));
    // R3
    loop_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_q[MCR_LOOP] |-> (msr_o[7:4] == mcr_q[3:0]));
endmodule

// File: tb/modem_status_tracker_tb.sv
module modem_status_tracker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_cts = 1'b0, line_dsr = 1'b0, line_ri = 1'b0, line_dcd = 1'b0;
    logic       mcr_wr = 1'b0;
    logic [7:0] mcr_wdata = 8'h00;
    logic       msr_rd = 1'b0;
    logic [7:0] mcr_q;
    logic [7:0] msr_o;
    logic       delta_any;
    int         total = 0;
    int         bad = 0;
    logic       done = 1'b0;

    always #2 clk = ~clk;

    modem_status_tracker u_dut (
        .clk(clk), .rst_n(rst_n),
        .line_cts(line_cts), .line_dsr(line_dsr), .line_ri(line_ri), .line_dcd(line_dcd),
        .mcr_wr(mcr_wr), .mcr_wdata(mcr_wdata), .msr_rd(msr_rd),
        .mcr_q(mcr_q), .msr_o(msr_o), .delta_any(delta_any)
    );

    // {written control byte, expected status byte, expected stored control byte}
    localparam logic [23:0] VEC [0:6] = '{
        {8'h10, 8'h00, 8'h10},   // enter loopback, all outputs low
        {8'h13, 8'h33, 8'h13},   // DTR,RTS -> CTS,DSR rise
        {8'h14, 8'h43, 8'h14},   // OUT1 only: CTS,DSR fall, RI rises (no flag)
        {8'h18, 8'h8C, 8'h18},   // RI falls -> trailing flag, DCD rises
        {8'hFF, 8'hF3, 8'h1F},   // reserved dropped, CTS,DSR,RI rise
        {8'h1F, 8'hF0, 8'h1F},   // no change
        {8'h0F, 8'h0F, 8'h0F}    // leave loopback: lines low, all fall
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic write_mcr(input logic [7:0] v);
        @(negedge clk); mcr_wr = 1'b1; mcr_wdata = v;
        @(negedge clk); mcr_wr = 1'b0;
    endtask

    task automatic read_msr();
        msr_rd = 1'b1;
        @(negedge clk); msr_rd = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mcr", mcr_q, 8'h00);
        chk("R1 msr", msr_o, 8'h00);
        chk("R1 any", {7'b0, delta_any}, 8'h00);

        // Table: loopback writes, mapping, flags, reserved bits, clear on read
        for (int k = 0; k < 7; k++) begin
            write_mcr(VEC[k][23:16]);
            @(negedge clk);
            chk("R3/R4/R5 msr", msr_o, VEC[k][15:8]);
            chk("R10 any", {7'b0, delta_any}, {7'b0, (VEC[k][11:8] != 4'h0)});
            chk("R2 mcr", mcr_q, VEC[k][7:0]);
            read_msr();
            chk("R6 cleared", msr_o, {VEC[k][15:12], 4'h0});
        end

        // R8: two-stage synchronizer latency, flag one edge later
        line_cts = 1'b1;
        @(negedge clk); chk("R8 first edge", msr_o, 8'h00);
        @(negedge clk); chk("R8 level", msr_o, 8'h10);
        @(negedge clk); chk("R8 flag", msr_o, 8'h11);
        chk("R10 any set", {7'b0, delta_any}, 8'h01);
        read_msr();
        chk("R6 read clears", msr_o, 8'h10);
        chk("R10 any clear", {7'b0, delta_any}, 8'h00);

        // R7: change flagged at the same edge as a read clear
        line_dsr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 pre-read byte", msr_o, 8'h30);
        read_msr();
        chk("R7 flag kept", msr_o, 8'h32);
        read_msr();
        chk("R6 clear after", msr_o, 8'h30);

        // R5: external RI rise gives no flag, fall gives one
        line_ri = 1'b1;
        wait_n(3);
        chk("R5 rise", msr_o, 8'h70);
        line_ri = 1'b0;
        wait_n(3);
        chk("R5 fall", msr_o, 8'h34);
        read_msr();
        chk("R5 cleared", msr_o, 8'h30);

        // R9: external lines ignored in loopback
        write_mcr(8'h13);
        @(negedge clk);
        chk("R9 enter same", msr_o, 8'h30);
        line_dcd = 1'b1; line_cts = 1'b0;
        wait_n(4);
        chk("R9 ignored", msr_o, 8'h30);
        chk("R9 any", {7'b0, delta_any}, 8'h00);

        // R4: leaving loopback exposes lines: CTS falls, DCD rises
        write_mcr(8'h00);
        @(negedge clk);
        chk("R4 leave loop", msr_o, 8'hA9);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule